// File: doc/BRIEF.md
# Serial-Addressed Channel Code Bank

This block is the digital control front end for an eight-channel, 8-bit converter. A host writes to it over a three-wire serial link made of a serial clock, an active-low select and a data line. Each write is an 11-bit word. The first three bits name a channel and the remaining eight bits carry that channel's code. When the select line returns high, the word in the serial register is committed to the addressed channel register. All other channels keep their values, so updating all eight channels takes eight separate frames.

The block runs on a fast system clock and oversamples the serial lines through synchronizers. It then acts on the edges it detects. All eight codes are presented in parallel on registered outputs, together with an output-enable flag. While the active-low shutdown input is asserted, the flag is low and the code outputs read zero. The stored codes are kept during shutdown and reappear when it is released. A synchronous reset returns every channel to mid-scale.

Top module: `sdac_ctrl`

## Requirements
- R1: In the cycle after `rst` is high, `chan_code` carries 8'h80 in every channel field and `out_en` is 1. The serial register is cleared to all zeros by reset.
- R2: While `ser_cs_n` is high, rising edges of `ser_clk` leave the serial register unchanged.
- R3: While `ser_cs_n` is low, each rising edge of `ser_clk` shifts the serial register left by one bit and takes `ser_din` into bit 0. The 11-bit word is sent MSB first. Its upper 3 bits (word bits 10..8) are the channel index, 0 to 7. Its lower 8 bits (word bits 7..0) are the code.
- R4: A rising edge of `ser_cs_n` writes the code to exactly the addressed channel, which appears on `chan_code[8*i+7:8*i]` for index i. Every other channel is unchanged, and nothing is written without such an edge.
- R5: If more than 11 bits are clocked in one frame, only the last 11 are used.
- R6: If fewer than 11 bits are clocked (including none), the frame still commits whatever the serial register holds. That is the earlier content shifted left by the number of new bits.
- R7: While `shdn_n` is low, `out_en` is 0 and `chan_code` is all zeros.
- R8: Shutdown does not alter the stored codes. After `shdn_n` returns high, the previous codes reappear with `out_en` at 1.
- R9: Frames received during shutdown still update the addressed channel. The new code is visible after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset; all channels go to mid-scale |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_cs_n | input | 1 | Active-low frame select; its rising edge commits the word |
| ser_din | input | 1 | Serial data, MSB first |
| shdn_n | input | 1 | Active-low shutdown |
| chan_code | output | NCH*CODE_W | All channel codes in parallel; channel i at bits [8*i+7:8*i] |
| out_en | output | 1 | High when the outputs are driven, low in shutdown |

## Verification
The assertions assume that the serial lines change slowly compared with `clk`. Each level of `ser_clk`, `ser_cs_n` and `ser_din` must last long enough to pass the synchronizers, and `ser_din` must be stable around every rising edge of `ser_clk`. They also assume that a rising edge of `ser_clk` never coincides with a transition of `ser_cs_n`. The stimulus meets these conditions by holding every serial level for four system clocks and by leaving idle gaps before and after each select transition. It then samples the outputs twelve cycles after a commit, which is well beyond the synchronizer, edge-detect, bank and output-register latency.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int DEF_NCH    = 8;
  localparam int DEF_CODE_W = 8;
  localparam int DEF_SYNC   = 2;

  // Mid-scale value for a code of width w: only the MSB set.
  function automatic logic [31:0] mid_scale(input int w);
    return 32'(1) << (w - 1);
  endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               cs_s,
  input  logic               din_s,
  output logic [FRAME_W-1:0] sr,
  output logic               commit
);

  logic sclk_d;
  logic cs_d;
  logic sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  // Select returning high ends the frame.
  assign commit    = cs_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      sr     <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      if (sclk_rise && !cs_s) sr <= {sr[FRAME_W-2:0], din_s};
    end
  end

endmodule

// File: rtl/sdac_decode.sv
module sdac_decode #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 3
) (
  input  logic              commit,
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    wr_vec
);

  for (genvar i = 0; i < NCH; i++) begin : g_sel
    assign wr_vec[i] = commit && (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/sdac_bank.sv
module sdac_bank #(
  parameter int NCH    = 8,
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        wr_vec,
  input  logic [CODE_W-1:0]     wr_code,
  output logic [NCH*CODE_W-1:0] bank_flat
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(sdac_pkg::mid_scale(CODE_W));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (rst)            code_q <= MID;
      else if (wr_vec[i]) code_q <= wr_code;
    end
    assign bank_flat[i*CODE_W +: CODE_W] = code_q;
  end

endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl #(
  parameter int NCH         = sdac_pkg::DEF_NCH,
  parameter int CODE_W      = sdac_pkg::DEF_CODE_W,
  parameter int SYNC_STAGES = sdac_pkg::DEF_SYNC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ser_clk,
  input  logic                  ser_cs_n,
  input  logic                  ser_din,
  input  logic                  shdn_n,
  output logic [NCH*CODE_W-1:0] chan_code,
  output logic                  out_en
);

  localparam int ADDR_W  = $clog2(NCH);
  localparam int FRAME_W = ADDR_W + CODE_W;
  localparam logic [CODE_W-1:0]     MID     = CODE_W'(sdac_pkg::mid_scale(CODE_W));
  localparam logic [NCH*CODE_W-1:0] MID_ALL = {NCH{MID}};

  logic [3:0]            raw_in;
  logic [3:0]            syn_out;
  logic                  sclk_s, cs_s, din_s, shdn_s;
  logic [FRAME_W-1:0]    sr;
  logic                  commit;
  logic [NCH-1:0]        wr_vec;
  logic [NCH*CODE_W-1:0] bank_flat;

  assign raw_in = {shdn_n, ser_din, ser_cs_n, ser_clk};

  sdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_out)
  );

  assign sclk_s = syn_out[0];
  assign cs_s   = syn_out[1];
  assign din_s  = syn_out[2];
  assign shdn_s = syn_out[3];

  sdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sclk_s),
    .cs_s   (cs_s),
    .din_s  (din_s),
    .sr     (sr),
    .commit (commit)
  );

  sdac_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .commit (commit),
    .addr   (sr[FRAME_W-1 -: ADDR_W]),
    .wr_vec (wr_vec)
  );

  sdac_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_vec    (wr_vec),
    .wr_code   (sr[CODE_W-1:0]),
    .bank_flat (bank_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_code <= MID_ALL;
      out_en    <= 1'b1;
    end else begin
      out_en    <= shdn_s;
      chan_code <= shdn_s ? bank_flat : '0;
    end
  end

endmodule

// File: rtl/sdac_ctrl_chk.sv
module sdac_ctrl_chk #(
  parameter int NCH     = 8,
  parameter int CODE_W  = 8,
  parameter int FRAME_W = 11
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cs_s,
  input logic                  shdn_s,
  input logic [FRAME_W-1:0]    sr,
  input logic                  commit,
  input logic [NCH-1:0]        wr_vec,
  input logic [NCH*CODE_W-1:0] bank_flat,
  input logic [NCH*CODE_W-1:0] chan_code,
  input logic                  out_en
);

  localparam logic [CODE_W-1:0]     MID     = CODE_W'(sdac_pkg::mid_scale(CODE_W));
  localparam logic [NCH*CODE_W-1:0] MID_ALL = {NCH{MID}};

  AST_RESET_MID: assert property (@(posedge clk) rst |=> (chan_code == MID_ALL && out_en)); // R1

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst) cs_s |=> $stable(sr)); // R2

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst) commit |-> $countones(wr_vec) == 1); // R4

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst) !commit |=> $stable(bank_flat)); // R4

  AST_SHDN_GATE: assert property (@(posedge clk) disable iff (rst) !shdn_s |=> (!out_en && chan_code == '0)); // R7

endmodule

bind sdac_ctrl sdac_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_s      (cs_s),
  .shdn_s    (shdn_s),
  .sr        (sr),
  .commit    (commit),
  .wr_vec    (wr_vec),
  .bank_flat (bank_flat),
  .chan_code (chan_code),
  .out_en    (out_en)
);

// File: tb/sdac_ctrl_tb.sv
`timescale 1ns/1ps
module sdac_ctrl_tb;

  localparam int NCH = 8;
  localparam int CW  = 8;
  localparam int FW  = 11;
  localparam int HOLD = 4;
  localparam int NVEC = 10;
  localparam logic [FW-1:0] VEC [NVEC] = '{
    {3'd0, 8'h12}, {3'd1, 8'hFF}, {3'd2, 8'h00}, {3'd3, 8'hA5},
    {3'd4, 8'h5A}, {3'd5, 8'h01}, {3'd6, 8'h80}, {3'd7, 8'h7E},
    {3'd3, 8'hC3}, {3'd0, 8'hFE}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_cs_n = 1'b1;
  logic ser_din = 1'b0;
  logic shdn_n = 1'b1;
  logic [NCH*CW-1:0] chan_code;
  logic out_en;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] mdl [NCH];
  logic [FW-1:0] msr;
  logic          mshdn = 1'b0;

  always #2.5 clk = ~clk;

  sdac_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .ser_clk   (ser_clk),
    .ser_cs_n  (ser_cs_n),
    .ser_din   (ser_din),
    .shdn_n    (shdn_n),
    .chan_code (chan_code),
    .out_en    (out_en)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) mdl[i] = 8'h80;
    msr = '0;
  endtask

  task automatic check(input string tag);
    logic [NCH*CW-1:0] exp_code;
    logic              exp_en;
    exp_en = !mshdn;
    for (int i = 0; i < NCH; i++) exp_code[i*CW +: CW] = mshdn ? 8'h00 : mdl[i];
    checks++;
    if (chan_code !== exp_code || out_en !== exp_en) begin
      errors++;
      $display("FAIL %s: chan_code=%h out_en=%b expected chan_code=%h out_en=%b",
               tag, chan_code, out_en, exp_code, exp_en);
    end
  endtask

  // Sends the low n bits of val, MSB first, as one frame.
  task automatic send_bits(input logic [31:0] val, input int n);
    ser_cs_n = 1'b0;
    wait_clk(HOLD);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = val[i];
      wait_clk(HOLD);
      ser_clk = 1'b1;
      msr = {msr[FW-2:0], val[i]};
      wait_clk(HOLD);
      ser_clk = 1'b0;
    end
    wait_clk(HOLD);
    ser_cs_n = 1'b1;
    mdl[msr[FW-1 -: 3]] = msr[CW-1:0];
    wait_clk(12);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    model_reset();
    wait_clk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset mid-scale");

    // R3 R4: table of frames, each checked against the per-channel model
    for (int v = 0; v < NVEC; v++) begin
      send_bits(32'(VEC[v]), FW);
      check($sformatf("R3/R4 vector %0d", v));
    end

    // R5: 4 leading junk bits then a word for channel 5
    send_bits({17'd0, 4'b1111, 3'd5, 8'h3C}, 15);
    check("R5 long frame keeps last 11 bits");

    // R6: 5-bit frame shifts existing content
    send_bits(32'b10110, 5);
    check("R6 short frame");

    // R6: empty frame commits current register unchanged
    send_bits(32'd0, 0);
    check("R6 empty frame");

    // R2: clock pulses with select high, then empty frame
    send_bits({21'd0, 3'd2, 8'h3C}, FW);
    check("R2 setup frame");
    ser_din = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wait_clk(HOLD);
      ser_clk = 1'b1;
      wait_clk(HOLD);
      ser_clk = 1'b0;
    end
    mdl[2] = 8'h00;  // visible change: put channel 2 aside and rewrite via empty frame
    send_bits(32'd0, 0);
    check("R2 clocks ignored while select high");

    // R7: shutdown gates outputs
    shdn_n = 1'b0;
    mshdn  = 1'b1;
    wait_clk(8);
    check("R7 shutdown outputs off");

    // R9: frame during shutdown, still gated
    send_bits({21'd0, 3'd6, 8'hD7}, FW);
    check("R9 write during shutdown stays hidden");

    // R8 R9: release restores old codes plus the new one
    shdn_n = 1'b1;
    mshdn  = 1'b0;
    wait_clk(8);
    check("R8/R9 release shows retained and new codes");

    // R1: reset mid-run, serial register cleared
    do_reset();
    check("R1 reset after writes");
    send_bits(32'd0, 0);
    check("R1 serial register cleared by reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule